// File: doc/BRIEF.md
# Multi-Channel Fractional Clock-Enable Generator

This block derives four independent rate-controlled tick streams from one reference clock. A single 32-bit control word, reached over a simple register bus, holds one byte per channel. Each byte carries a 6-bit divisor and a gate bit. While its gate is open, a channel reports in every reference cycle how many output ticks fall in that cycle. The long-run tick rate equals the reference rate times 18 divided by the channel's divisor. The permitted divisor span is 12 to 35, so a channel may run faster than the reference, at up to 1.5 ticks per cycle. A rate above one per cycle cannot come from a single enable line. For that reason each channel reports a 2-bit tick count of 0, 1 or 2, together with an enable flag that is high whenever the count is nonzero.

Software can rewrite the whole word directly. It can also use three alias offsets that OR, XOR or clear bits, so that one channel's field can change without a read-modify-write. Each channel keeps a remainder accumulator. Every cycle the accumulator gains 18, and it loses the divisor once for each tick emitted. A new divisor therefore acts on the next cycle and leaves the phase of the stream in place.

Top module: `fracclk_en_gen`

## Requirements
- R1: After reset the control word reads 0x92929292: every gate bit is 1 and every divisor is 18. All tick counts and enable flags are 0.
- R2: A write to byte offset 0x0 (reg_addr[3:2] = 0) replaces the word. Bit 6 of each byte is reserved: it reads as 0 and ignores all writes.
- R3: A write to offset 0x4 (reg_addr[3:2] = 1) ORs the write data into the word.
- R4: A write to offset 0x8 (reg_addr[3:2] = 2) XORs the write data into the word.
- R5: A write to offset 0xC (reg_addr[3:2] = 3) clears each bit that is 1 in the write data.
- R6: A read at any of the four offsets returns the current word, and the word changes only on a write strobe.
- R7: Channel n's gate bit is bit 8n+7. While it is 1, tick count n is 0 from the next cycle and the channel's accumulator is cleared. After the gate is released, a channel with divisor 27 reports 0, 1, 1 in its first three running cycles.
- R8: Channel n's divisor is bits [8n+5:8n]. Its tick count is tick_cnt[2n+1:2n], registered, and never exceeds 2. Over N cycles that start from a cleared accumulator, the sum of the counts is floor(18N/divisor).
- R9: A divisor below 12 acts as 12 and a divisor above 35 acts as 35. The stored bits keep the value that was written.
- R10: A divisor change acts in the cycle after the write and does not clear the accumulator. For example, one cycle at 35 followed by a switch to 12 yields a count of 2.
- R11: tick_en[n] is 1 exactly when tick count n is nonzero. The channels run independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Byte address; bits [3:2] select the write operation |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Current control word |
| tick_cnt | output | 8 | Per-channel tick count, 2 bits per channel |
| tick_en | output | 4 | Per-channel nonzero-count flag |

## Verification
The bench targets the corner cases that break a fractional divider quietly. At divisor 12 every other cycle must report two ticks; a design that capped the count at one would come up short on the 70-cycle totals. Out-of-range divisors 0, 5 and 63 must saturate; without saturation a zero divisor would stall or run away, and the totals would show it. A divisor changed mid-stream must reuse the running remainder, and a design that reset the accumulator on every write would report one tick where two are due. The bench also checks that the reserved bit stays 0 under every alias operation and that releasing a gate restarts the stream from a cleared remainder.

// File: rtl/fcg_pkg.sv
package fcg_pkg;

   // Write operation selected by the upper address bits.
   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_TOGGLE = 2'd2,
      OP_CLEAR  = 2'd3
   } wr_op_e;

   function automatic wr_op_e decode_op(input logic [1:0] sel);
      return wr_op_e'(sel);
   endfunction

   // Apply one aliased write to the current word under a writable mask.
   function automatic logic [31:0] apply_op(input wr_op_e op,
                                            input logic [31:0] cur,
                                            input logic [31:0] data,
                                            input logic [31:0] mask);
      logic [31:0] d;
      d = data & mask;
      case (op)
         OP_WRITE:  return d;
         OP_SET:    return (cur | d) & mask;
         OP_TOGGLE: return (cur ^ d) & mask;
         default:   return cur & ~d & mask;
      endcase
   endfunction

endpackage

// File: rtl/fcg_ctrl_regs.sv
module fcg_ctrl_regs
   import fcg_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int LANE_W   = 8,
   parameter int FRAC_W   = 6,
   parameter int RST_FRAC = 18,
   parameter int ADDR_W   = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NUM_CH*LANE_W-1:0] wdata,
   input  logic                     we,
   output logic [NUM_CH*LANE_W-1:0] rdata,
   output logic [NUM_CH*LANE_W-1:0] word_q
);
   localparam int DATA_W   = NUM_CH * LANE_W;
   localparam int GATE_POS = LANE_W - 1;
   localparam int OP_LSB   = 2;
   localparam logic [LANE_W-1:0] LANE_MASK =
      LANE_W'((2 ** FRAC_W - 1) + 2 ** GATE_POS);
   localparam logic [LANE_W-1:0] LANE_RST  =
      LANE_W'(RST_FRAC + 2 ** GATE_POS);

   initial begin : p_param_chk
      assert (DATA_W == 32) else $error("control word must be 32 bits");
      assert (ADDR_W >= OP_LSB + 2) else $error("address too narrow");
      assert (FRAC_W < GATE_POS) else $error("divisor overlaps gate bit");
      assert (RST_FRAC < 2 ** FRAC_W) else $error("reset divisor too wide");
   end

   logic [DATA_W-1:0] wmask;
   logic [DATA_W-1:0] rst_val;
   logic [DATA_W-1:0] word_nxt;
   wr_op_e            op;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      assign wmask[c*LANE_W +: LANE_W]   = LANE_MASK;
      assign rst_val[c*LANE_W +: LANE_W] = LANE_RST;
   end

   assign op = decode_op(addr[OP_LSB +: 2]);

   always_comb begin
      word_nxt = apply_op(op, word_q, wdata, wmask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= rst_val;
      else if (we) word_q <= word_nxt;
   end

   assign rdata = word_q;

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata & ~wmask) == '0);                                          // R2
   AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && op == OP_SET) |=>
      ((word_q & $past(wdata & wmask)) == $past(wdata & wmask)));        // R3
   AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && op == OP_TOGGLE) |=>
      (((word_q ^ $past(word_q)) & $past(wmask)) == $past(wdata & wmask))); // R4
   AST_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && op == OP_CLEAR) |=> ((word_q & $past(wdata)) == '0));      // R5
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(word_q));                                         // R6
endmodule

// File: rtl/fcg_frac_clamp.sv
module fcg_frac_clamp #(
   parameter int FRAC_W   = 6,
   parameter int FRAC_MIN = 12,
   parameter int FRAC_MAX = 35,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic [FRAC_W-1:0] frac_raw,
   output logic [FRAC_W-1:0] frac_eff
);
   localparam logic [FRAC_W-1:0] LO = FRAC_W'(FRAC_MIN);
   localparam logic [FRAC_W-1:0] HI = FRAC_W'(FRAC_MAX);

   initial begin : p_param_chk
      assert (FRAC_MIN > 0 && FRAC_MIN <= FRAC_MAX)
         else $error("bad divisor range");
      assert (FRAC_MAX < 2 ** FRAC_W) else $error("divisor max too wide");
   end

   if (CLAMP_EN) begin : g_clamp
      always_comb begin
         if (frac_raw < LO)      frac_eff = LO;
         else if (frac_raw > HI) frac_eff = HI;
         else                    frac_eff = frac_raw;
      end
   end else begin : g_pass
      assign frac_eff = frac_raw;
   end
endmodule

// File: rtl/fcg_lane.sv
module fcg_lane #(
   parameter int FRAC_W   = 6,
   parameter int NUMER    = 18,
   parameter int FRAC_MIN = 12,
   parameter int FRAC_MAX = 35,
   parameter int CNT_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FRAC_W-1:0] frac,
   input  logic              gate,
   output logic [CNT_W-1:0]  ticks_q,
   output logic              en_q
);
   localparam int SUM_W  = $clog2(FRAC_MAX + NUMER);
   localparam int WORK_W = (SUM_W > FRAC_W + 1) ? SUM_W + 1 : FRAC_W + 2;

   initial begin : p_param_chk
      assert (NUMER < 2 * FRAC_MIN) else $error("two ticks per cycle insufficient");
      assert (CNT_W >= 2) else $error("tick count too narrow");
   end

   logic [SUM_W-1:0]  acc_q, acc_nxt;
   logic [WORK_W-1:0] sum, f1, f2;
   logic [CNT_W-1:0]  cnt_nxt;

   always_comb begin
      sum     = WORK_W'(acc_q) + WORK_W'(NUMER);
      f1      = WORK_W'(frac);
      f2      = f1 << 1;
      cnt_nxt = '0;
      acc_nxt = SUM_W'(sum);
      if (sum >= f2) begin
         cnt_nxt = CNT_W'(2);
         acc_nxt = SUM_W'(sum - f2);
      end else if (sum >= f1) begin
         cnt_nxt = CNT_W'(1);
         acc_nxt = SUM_W'(sum - f1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         ticks_q <= '0;
         en_q    <= 1'b0;
      end else if (gate) begin
         acc_q   <= '0;
         ticks_q <= '0;
         en_q    <= 1'b0;
      end else begin
         acc_q   <= acc_nxt;
         ticks_q <= cnt_nxt;
         en_q    <= (cnt_nxt != '0);
      end
   end

   AST_TICK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ticks_q <= CNT_W'(2));                                            // R8
   AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q < SUM_W'(FRAC_MAX));                                        // R8
   AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      gate |=> (ticks_q == '0 && acc_q == '0));                         // R7
   AST_EN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      en_q == (ticks_q != '0));                                         // R11
endmodule

// File: rtl/fracclk_en_gen.sv
module fracclk_en_gen #(
   parameter int NUM_CH   = 4,
   parameter int LANE_W   = 8,
   parameter int FRAC_W   = 6,
   parameter int NUMER    = 18,
   parameter int FRAC_MIN = 12,
   parameter int FRAC_MAX = 35,
   parameter int RST_FRAC = 18,
   parameter int ADDR_W   = 4,
   parameter int CNT_W    = 2,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic                     clk_ref,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [NUM_CH*LANE_W-1:0] reg_wdata,
   input  logic                     reg_we,
   output logic [NUM_CH*LANE_W-1:0] reg_rdata,
   output logic [NUM_CH*CNT_W-1:0]  tick_cnt,
   output logic [NUM_CH-1:0]        tick_en
);
   localparam int DATA_W   = NUM_CH * LANE_W;
   localparam int GATE_POS = LANE_W - 1;

   logic [DATA_W-1:0] word_q;

   fcg_ctrl_regs #(
      .NUM_CH(NUM_CH), .LANE_W(LANE_W), .FRAC_W(FRAC_W),
      .RST_FRAC(RST_FRAC), .ADDR_W(ADDR_W)
   ) i_regs (
      .clk(clk_ref), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
      .we(reg_we), .rdata(reg_rdata), .word_q(word_q)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [FRAC_W-1:0] frac_eff;

      fcg_frac_clamp #(
         .FRAC_W(FRAC_W), .FRAC_MIN(FRAC_MIN), .FRAC_MAX(FRAC_MAX),
         .CLAMP_EN(CLAMP_EN)
      ) i_clamp (
         .frac_raw(word_q[c*LANE_W +: FRAC_W]),
         .frac_eff(frac_eff)
      );

      AST_FRAC_RANGE: assert property (@(posedge clk_ref) disable iff (!rst_n)
         (!CLAMP_EN) || (frac_eff >= FRAC_W'(FRAC_MIN) &&
                         frac_eff <= FRAC_W'(FRAC_MAX)));               // R9

      fcg_lane #(
         .FRAC_W(FRAC_W), .NUMER(NUMER), .FRAC_MIN(FRAC_MIN),
         .FRAC_MAX(FRAC_MAX), .CNT_W(CNT_W)
      ) i_lane (
         .clk(clk_ref), .rst_n(rst_n), .frac(frac_eff),
         .gate(word_q[c*LANE_W + GATE_POS]),
         .ticks_q(tick_cnt[c*CNT_W +: CNT_W]),
         .en_q(tick_en[c])
      );
   end
endmodule

// File: tb/test_fracclk_en_gen.sv
module test_fracclk_en_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic [31:0] rdata;
   logic [7:0]  ticks;
   logic [3:0]  en;

   int n_chk = 0;
   int n_fail = 0;
   int tot [4];

   always #10 clk = ~clk;

   fracclk_en_gen i_fracclk_en_gen (
      .clk_ref(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata),
      .reg_we(we), .reg_rdata(rdata), .tick_cnt(ticks), .tick_en(en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); @(negedge clk);
      we = 1'b0; addr = '0; wdata = '0;
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   function automatic logic [1:0] tk(input int c);
      return ticks[2*c +: 2];
   endfunction

   // Run n cycles and accumulate per-channel totals; flag bad samples.
   task automatic run_count(input int n);
      int bad = 0;
      for (int c = 0; c < 4; c++) tot[c] = 0;
      for (int i = 0; i < n; i++) begin
         step();
         for (int c = 0; c < 4; c++) begin
            tot[c] += int'(tk(c));
            if (tk(c) > 2'd2 || en[c] !== (tk(c) != 2'd0)) bad++;
         end
      end
      chk("R11 enable matches count", bad, 0);
   endtask

   task automatic t_reset();
      chk("R1 reset word", rdata, 32'h92929292);
      chk("R1 reset ticks", {24'h0, ticks}, 32'h0);
      chk("R1 reset enables", {28'h0, en}, 32'h0);
   endtask

   task automatic t_direct();
      bus_wr(4'h0, 32'hFFFFFFFF);
      chk("R2 reserved bits read zero", rdata, 32'hBFBFBFBF);
      bus_wr(4'h0, 32'hCCA30D9F);
      chk("R2 direct write", rdata, 32'h8CA30D9F);
   endtask

   task automatic t_alias();
      bus_wr(4'h4, 32'h41002060);
      chk("R3 set alias", rdata, 32'h8DA32DBF);
      addr = 4'h4; #1;
      chk("R6 read at 0x4", rdata, 32'h8DA32DBF);
      bus_wr(4'h8, 32'h0F4F0F0F);
      chk("R4 toggle alias", rdata, 32'h82AC22B0);
      addr = 4'h8; #1;
      chk("R6 read at 0x8", rdata, 32'h82AC22B0);
      bus_wr(4'hC, 32'hF0000080);
      chk("R5 clear alias", rdata, 32'h02AC2230);
      addr = 4'hC; #1;
      chk("R6 read at 0xC", rdata, 32'h02AC2230);
      addr = 4'h0;
      step(); step();
      chk("R6 word stable without strobe", rdata, 32'h02AC2230);
   endtask

   task automatic t_rate();
      bus_wr(4'h0, 32'h80808080);
      bus_wr(4'h0, 32'h231B120C);
      run_count(70);
      chk("R8 total at divisor 12", tot[0], 105);
      chk("R8 total at divisor 18", tot[1], 70);
      chk("R8 total at divisor 27", tot[2], 46);
      chk("R8 total at divisor 35", tot[3], 36);
   endtask

   task automatic t_gate();
      bus_wr(4'h4, 32'h00800000);
      for (int i = 0; i < 5; i++) begin
         step();
         chk("R7 gated channel silent", {30'h0, tk(2)}, 32'd0);
         chk("R11 neighbour keeps running", {30'h0, tk(1)}, 32'd1);
      end
      bus_wr(4'hC, 32'h00800000);
      chk("R7 still silent at release edge", {30'h0, tk(2)}, 32'd0);
      step(); chk("R7 restart cycle 1", {30'h0, tk(2)}, 32'd0);
      step(); chk("R7 restart cycle 2", {30'h0, tk(2)}, 32'd1);
      step(); chk("R7 restart cycle 3", {30'h0, tk(2)}, 32'd1);
   endtask

   task automatic t_sat();
      bus_wr(4'h0, 32'h80808080);
      bus_wr(4'h0, 32'h3F3F0500);
      chk("R9 stored bits kept", rdata, 32'h3F3F0500);
      run_count(70);
      chk("R9 divisor 0 acts as 12", tot[0], 105);
      chk("R9 divisor 5 acts as 12", tot[1], 105);
      chk("R9 divisor 63 acts as 35", tot[2], 36);
      chk("R9 divisor 63 acts as 35", tot[3], 36);
   endtask

   task automatic t_change();
      bus_wr(4'h0, 32'h80808080);
      bus_wr(4'h0, 32'h80808023);
      bus_wr(4'h0, 32'h8080800C);
      chk("R10 first cycle at old divisor", {30'h0, tk(0)}, 32'd0);
      step();
      chk("R10 new divisor with kept remainder", {30'h0, tk(0)}, 32'd2);
   endtask

   initial begin : p_watchdog
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : p_main
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_direct();
      t_alias();
      t_rate();
      t_gate();
      t_sat();
      t_change();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule